// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This unit settles conditional branches while they sit in the decode stage of a five-stage in-order pipeline. It tests a register operand against zero and adds the scaled, sign-extended offset to the branch's incremented PC in the same stage. A taken branch therefore costs one lost fetch slot instead of three. It reports whether fetch must be redirected, the branch target, the resolved successor address, and whether the instruction already fetched behind the branch must be turned into a no-op.

The parameter `DELAY_SLOT` chooses between two policies. When it is 0, fetch assumes the branch is not taken: it carries on at the sequential address, and the instruction behind the branch is squashed by clearing its IF/ID valid bit, but only when the branch is taken. When it is 1, the instruction after the branch is an architectural delay slot that always executes, and no squash is ever requested.

The operand comes straight from the register read in decode, so the unit cannot evaluate a branch whose register is still being written by the instruction in EX. In that case it asks for a single stall cycle and evaluates on the following cycle.

Top module: `decode_branch_resolver`

## Requirements
- R1: `target_o` equals `pc_plus4_i` plus the 16-bit `offset_i`, sign-extended and shifted left by 2, modulo 2^32.
- R2: With `br_kind_i` = 2'b01 (branch if zero) the branch is taken iff `rs_val_i` is 0. With 2'b10 (branch if non-zero) it is taken iff `rs_val_i` is not 0. A taken branch that is not stalled asserts `redirect_o`.
- R3: When `id_valid_i` is low, or `br_kind_i` is 2'b00 or 2'b11, `redirect_o`, `squash_o` and `stall_o` are all low and `next_pc_o` equals `pc_plus4_i`.
- R4: With `DELAY_SLOT`=0, `squash_o` equals `redirect_o`.
- R5: With `DELAY_SLOT`=1, `squash_o` is never asserted. `redirect_o` behaves exactly as with `DELAY_SLOT`=0.
- R6: `stall_o` rises when a valid branch tests register `rs_idx_i` != 0, and `ex_wr_en_i` is high with `ex_rd_i` == `rs_idx_i`. While `stall_o` is high, `redirect_o` and `squash_o` stay low.
- R7: `stall_o` is never high in two consecutive cycles. In the cycle after a stall the branch evaluates even if the EX match is still present.
- R8: `next_pc_o` equals `target_o` when `redirect_o` is high, and `pc_plus4_i` otherwise.
- R9: After reset the stall history is clear, so the first hazard seen after reset stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| id_valid_i | input | 1 | Decode slot holds a live instruction |
| br_kind_i | input | 2 | 00 none, 01 branch if zero, 10 branch if non-zero, 11 none |
| rs_idx_i | input | 5 | Index of the tested register |
| rs_val_i | input | 32 | Value of the tested register |
| offset_i | input | 16 | Branch offset in instruction words |
| pc_plus4_i | input | 32 | Address of the branch plus 4 |
| ex_wr_en_i | input | 1 | Instruction in EX writes a register |
| ex_rd_i | input | 5 | Destination index of the instruction in EX |
| stall_o | output | 1 | Hold fetch and decode for one cycle |
| redirect_o | output | 1 | Fetch must continue at `next_pc_o` |
| target_o | output | 32 | Taken-branch target |
| next_pc_o | output | 32 | Resolved successor address |
| squash_o | output | 1 | Clear the IF/ID valid bit |

## Verification
The bench sweeps every branch encoding against zero, positive and negative operands. It does this with and without a valid decode slot, on two instances that differ only in policy. A resolver that inverted one condition, or let the reserved code act as a branch, would redirect on a fall-through. A resolver that squashed in delay-slot mode would throw away an instruction that must run.

Offsets at both extremes and across the sign boundary are paired with PCs near the wrap point. A missing sign extension or a missing shift therefore produces a wrong target.

Hazard cases hold the EX match for several cycles. A resolver that stalled forever would hang the pipeline, and one that evaluated during the stall would branch on a stale operand. Register 0 and non-writing EX instructions are checked to confirm that they cause no stall.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  typedef enum logic [1:0] {
    BK_NONE = 2'b00,
    BK_EQZ  = 2'b01,
    BK_NEZ  = 2'b10,
    BK_RSVD = 2'b11
  } br_kind_e;

  function automatic logic is_cond_branch(input br_kind_e k);
    return (k == BK_EQZ) || (k == BK_NEZ);
  endfunction
endpackage

// File: rtl/dbr_cond.sv
module dbr_cond
  import dbr_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            valid_i,
  input  br_kind_e        kind_i,
  input  logic [XLEN-1:0] val_i,
  output logic            is_br_o,
  output logic            taken_o
);
  logic is_zero;

  assign is_zero = (val_i == '0);
  assign is_br_o = valid_i && is_cond_branch(kind_i);

  always_comb begin
    taken_o = 1'b0;
    if (valid_i) begin
      unique case (kind_i)
        BK_EQZ:  taken_o = is_zero;
        BK_NEZ:  taken_o = !is_zero;
        default: taken_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/dbr_target.sv
module dbr_target #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned OFF_W = 16,
  parameter int unsigned SHIFT = 2
) (
  input  logic [XLEN-1:0]  base_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [XLEN-1:0]  target_o
);
  localparam int unsigned EXT_W = XLEN - OFF_W - SHIFT;

  logic [XLEN-1:0] disp;

  generate
    if (SHIFT == 0) begin : g_noshift
      assign disp = {{EXT_W{off_i[OFF_W-1]}}, off_i};
    end else begin : g_shift
      assign disp = {{EXT_W{off_i[OFF_W-1]}}, off_i, {SHIFT{1'b0}}};
    end
  endgenerate

  assign target_o = base_i + disp;
endmodule

// File: rtl/dbr_hazard.sv
module dbr_hazard #(
  parameter int unsigned RA_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            br_i,
  input  logic [RA_W-1:0] rs_idx_i,
  input  logic            ex_wr_en_i,
  input  logic [RA_W-1:0] ex_rd_i,
  output logic            stall_o
);
  logic match;
  logic stalled_q;

  assign match   = br_i && ex_wr_en_i && (ex_rd_i == rs_idx_i) && (rs_idx_i != '0);
  // one bubble suffices: producer has left EX by the next cycle
  assign stall_o = match && !stalled_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stalled_q <= 1'b0;
    else         stalled_q <= stall_o;
  end
endmodule

// File: rtl/dbr_policy.sv
module dbr_policy #(
  parameter bit DELAY_SLOT = 1'b0
) (
  input  logic taken_i,
  input  logic stall_i,
  output logic redirect_o,
  output logic squash_o
);
  assign redirect_o = taken_i && !stall_i;

  generate
    if (DELAY_SLOT) begin : g_slot
      assign squash_o = 1'b0;
    end else begin : g_pnt
      assign squash_o = redirect_o;
    end
  endgenerate
endmodule

// File: rtl/decode_branch_resolver.sv
module decode_branch_resolver
  import dbr_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned OFF_W      = 16,
  parameter int unsigned RA_W       = 5,
  parameter int unsigned SHIFT      = 2,
  parameter bit          DELAY_SLOT = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             id_valid_i,
  input  logic [1:0]       br_kind_i,
  input  logic [RA_W-1:0]  rs_idx_i,
  input  logic [XLEN-1:0]  rs_val_i,
  input  logic [OFF_W-1:0] offset_i,
  input  logic [XLEN-1:0]  pc_plus4_i,
  input  logic             ex_wr_en_i,
  input  logic [RA_W-1:0]  ex_rd_i,
  output logic             stall_o,
  output logic             redirect_o,
  output logic [XLEN-1:0]  target_o,
  output logic [XLEN-1:0]  next_pc_o,
  output logic             squash_o
);
  br_kind_e kind;
  logic     is_br;
  logic     taken;

  assign kind = br_kind_e'(br_kind_i);

  dbr_cond #(.XLEN(XLEN)) u_cond (
    .valid_i (id_valid_i),
    .kind_i  (kind),
    .val_i   (rs_val_i),
    .is_br_o (is_br),
    .taken_o (taken)
  );

  dbr_target #(.XLEN(XLEN), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_target (
    .base_i   (pc_plus4_i),
    .off_i    (offset_i),
    .target_o (target_o)
  );

  dbr_hazard #(.RA_W(RA_W)) u_hazard (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .br_i       (is_br),
    .rs_idx_i   (rs_idx_i),
    .ex_wr_en_i (ex_wr_en_i),
    .ex_rd_i    (ex_rd_i),
    .stall_o    (stall_o)
  );

  dbr_policy #(.DELAY_SLOT(DELAY_SLOT)) u_policy (
    .taken_i    (taken),
    .stall_i    (stall_o),
    .redirect_o (redirect_o),
    .squash_o   (squash_o)
  );

  assign next_pc_o = redirect_o ? target_o : pc_plus4_i;
endmodule

// File: rtl/dbr_checker.sv
module dbr_checker #(
  parameter int unsigned XLEN       = 32,
  parameter bit          DELAY_SLOT = 1'b0
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            id_valid_i,
  input logic [1:0]      br_kind_i,
  input logic [XLEN-1:0] rs_val_i,
  input logic [XLEN-1:0] pc_plus4_i,
  input logic            stall_o,
  input logic            redirect_o,
  input logic [XLEN-1:0] target_o,
  input logic [XLEN-1:0] next_pc_o,
  input logic            squash_o
);
  AST_EQZ_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_valid_i && br_kind_i == 2'b01 && !stall_o) |-> (redirect_o == (rs_val_i == '0))); // R2
  AST_NEZ_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_valid_i && br_kind_i == 2'b10 && !stall_o) |-> (redirect_o == (rs_val_i != '0))); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!id_valid_i || br_kind_i == 2'b00 || br_kind_i == 2'b11) |-> (!redirect_o && !stall_o && !squash_o)); // R3
  AST_STALL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (!redirect_o && !squash_o)); // R6
  AST_STALL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !stall_o); // R7
  AST_NEXT_PC_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o ? (next_pc_o == target_o) : (next_pc_o == pc_plus4_i)); // R8

  generate
    if (DELAY_SLOT) begin : g_slot
      AST_SLOT_NO_SQUASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !squash_o); // R5
    end else begin : g_pnt
      AST_SQUASH_ON_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        squash_o == redirect_o); // R4
    end
  endgenerate
endmodule

bind decode_branch_resolver dbr_checker #(.XLEN(XLEN), .DELAY_SLOT(DELAY_SLOT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .id_valid_i (id_valid_i),
  .br_kind_i  (br_kind_i),
  .rs_val_i   (rs_val_i),
  .pc_plus4_i (pc_plus4_i),
  .stall_o    (stall_o),
  .redirect_o (redirect_o),
  .target_o   (target_o),
  .next_pc_o  (next_pc_o),
  .squash_o   (squash_o)
);

// File: tb/decode_branch_resolver_tb_top.sv
module decode_branch_resolver_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        id_valid_i = 1'b0;
  logic [1:0]  br_kind_i = 2'b00;
  logic [4:0]  rs_idx_i = '0;
  logic [31:0] rs_val_i = '0;
  logic [15:0] offset_i = '0;
  logic [31:0] pc_plus4_i = '0;
  logic        ex_wr_en_i = 1'b0;
  logic [4:0]  ex_rd_i = '0;

  logic        stall_a, redir_a, squash_a;
  logic [31:0] tgt_a, npc_a;
  logic        stall_b, redir_b, squash_b;
  logic [31:0] tgt_b, npc_b;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  decode_branch_resolver #(.DELAY_SLOT(1'b0)) dut_i (
    .clk_i, .rst_ni, .id_valid_i, .br_kind_i, .rs_idx_i, .rs_val_i, .offset_i,
    .pc_plus4_i, .ex_wr_en_i, .ex_rd_i,
    .stall_o(stall_a), .redirect_o(redir_a), .target_o(tgt_a),
    .next_pc_o(npc_a), .squash_o(squash_a)
  );

  decode_branch_resolver #(.DELAY_SLOT(1'b1)) dut_ds_i (
    .clk_i, .rst_ni, .id_valid_i, .br_kind_i, .rs_idx_i, .rs_val_i, .offset_i,
    .pc_plus4_i, .ex_wr_en_i, .ex_rd_i,
    .stall_o(stall_b), .redirect_o(redir_b), .target_o(tgt_b),
    .next_pc_o(npc_b), .squash_o(squash_b)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  function automatic logic [31:0] exp_tgt(input logic [31:0] pc4, input logic [15:0] off);
    int signed o;
    o = int'($signed(off));
    return pc4 + 32'(o * 4);
  endfunction

  // drive at negedge, sample 1 ns later, then let the clock edge pass
  task automatic settle();
    @(negedge clk_i);
    #1;
  endtask

  logic [15:0] offs [8] = '{16'h0000, 16'h0001, 16'h7fff, 16'h8000,
                            16'hffff, 16'h0100, 16'hfff0, 16'h1234};
  logic [31:0] pcs  [3] = '{32'h0000_0004, 32'hffff_fffc, 32'h8000_0000};
  logic [31:0] vals [3] = '{32'h0, 32'h1, 32'h8000_0000};

  initial begin
    // R9: reset clears stall history; hazard present while in reset
    id_valid_i = 1'b1; br_kind_i = 2'b01; rs_idx_i = 5'd3; ex_wr_en_i = 1'b1; ex_rd_i = 5'd3;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R9 stall before release", {31'b0, stall_a}, 32'd1);
    @(negedge clk_i); rst_ni = 1'b1;
    #1;
    chk("R9 first hazard stalls", {31'b0, stall_a}, 32'd1);
    chk("R9 redirect low", {31'b0, redir_a}, 32'd0);
    ex_wr_en_i = 1'b0;
    @(posedge clk_i);

    // R1..R5, R8 sweep
    for (int oi = 0; oi < 8; oi++) begin
      for (int pi = 0; pi < 3; pi++) begin
        for (int k = 0; k < 4; k++) begin
          for (int vi = 0; vi < 3; vi++) begin
            for (int v = 0; v < 2; v++) begin
              logic tk;
              logic [31:0] et;
              @(negedge clk_i);
              id_valid_i = v[0]; br_kind_i = k[1:0]; rs_val_i = vals[vi];
              offset_i = offs[oi]; pc_plus4_i = pcs[pi]; rs_idx_i = 5'd7;
              ex_wr_en_i = 1'b0; ex_rd_i = 5'd7;
              #1;
              et = exp_tgt(pcs[pi], offs[oi]);
              tk = v[0] && ((k == 1 && vals[vi] == 0) || (k == 2 && vals[vi] != 0));
              chk("R1 target", tgt_a, et);
              chk("R2 R3 redirect", {31'b0, redir_a}, {31'b0, tk});
              chk("R4 squash", {31'b0, squash_a}, {31'b0, tk});
              chk("R5 delay-slot redirect", {31'b0, redir_b}, {31'b0, tk});
              chk("R5 delay-slot squash", {31'b0, squash_b}, 32'd0);
              chk("R8 next pc", npc_a, tk ? et : pcs[pi]);
              chk("R8 next pc slot", npc_b, tk ? et : pcs[pi]);
              chk("R3 no stall", {31'b0, stall_a}, 32'd0);
            end
          end
        end
      end
    end

    // R6/R7: held hazard, taken branch-if-nonzero
    @(negedge clk_i);
    id_valid_i = 1'b1; br_kind_i = 2'b10; rs_idx_i = 5'd9; rs_val_i = 32'd5;
    offset_i = 16'h0010; pc_plus4_i = 32'h0000_1000; ex_wr_en_i = 1'b1; ex_rd_i = 5'd9;
    #1;
    chk("R6 stall raised", {31'b0, stall_a}, 32'd1);
    chk("R6 no redirect in stall", {31'b0, redir_a}, 32'd0);
    chk("R6 no squash in stall", {31'b0, squash_a}, 32'd0);
    chk("R6 next pc in stall", npc_a, 32'h0000_1000);
    settle();
    chk("R7 stall released", {31'b0, stall_a}, 32'd0);
    chk("R7 evaluates after stall", {31'b0, redir_a}, 32'd1);
    chk("R7 target after stall", npc_a, 32'h0000_1040);
    chk("R7 squash after stall", {31'b0, squash_a}, 32'd1);
    chk("R7 slot squash after stall", {31'b0, squash_b}, 32'd0);
    settle();
    chk("R7 new stall next cycle", {31'b0, stall_a}, 32'd1);

    // R6: no stall for register 0, mismatch, or non-writing EX
    @(negedge clk_i); rs_idx_i = 5'd0; ex_rd_i = 5'd0; #1;
    chk("R6 r0 no stall", {31'b0, stall_a}, 32'd0);
    chk("R6 r0 redirect", {31'b0, redir_a}, 32'd1);
    @(negedge clk_i); rs_idx_i = 5'd9; ex_rd_i = 5'd8; #1;
    chk("R6 mismatch no stall", {31'b0, stall_a}, 32'd0);
    @(negedge clk_i); ex_rd_i = 5'd9; ex_wr_en_i = 1'b0; #1;
    chk("R6 no write no stall", {31'b0, stall_a}, 32'd0);
    @(negedge clk_i); ex_wr_en_i = 1'b1; id_valid_i = 1'b0; #1;
    chk("R3 invalid no stall", {31'b0, stall_a}, 32'd0);
    @(negedge clk_i); id_valid_i = 1'b1; br_kind_i = 2'b11; #1;
    chk("R3 reserved no stall", {31'b0, stall_a}, 32'd0);
    chk("R3 reserved next pc", npc_a, 32'h0000_1000);

    done = 1'b1;
    finish_run();
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      finish_run();
    end
  end
endmodule